// File: doc/BRIEF.md
# System Reset Controller with Sticky Cause Flags

This block gathers every reset request on the chip and turns it into three registered reset outputs. The first resets the whole system. The second resets only the processor and its flash controller. The third holds the DMA engine in reset. The requests come from the supply monitor, the external reset pin, the watchdog, the low-voltage and brown-out monitors, the processor's own system-reset request, and two software one-shot bits. Software can also hold the DMA engine in reset with a level bit that stays set until it is written back to zero.

A byte of cause flags records every source that fired. These flags sit in the block's own power-up domain, so the chip reset they record does not clear them. Firmware reads the flags after it boots and clears each one by writing 1 to it. A 16-bit code field can switch off the supply monitor's request, but only when it holds one key value. Any reset at chip level returns that field to zero.

The software reset bits and the code field accept writes only while the protection block drives the unlock input high. The cause flags can always be cleared.

Top module: `sysrst_ctrl`

## Requirements
- R1: While `rst` is high, all three reset outputs are driven high. The first clock edge after `rst` falls leaves the cause flags at 0x01 and the control bits and code field at 0.
- R2: Each of these sources raises `sys_rst_o`, `cpu_rst_o` and `dma_rst_o` on the next clock edge, and they stay high while the source stays asserted: the pin, watchdog, low-voltage, brown-out and system-request inputs, an enabled supply-monitor request, and an active chip one-shot.
- R3: Cause flags sit at register address 0. Bit 0 is the supply monitor or chip one-shot, bit 1 the pin, bit 2 the watchdog, bit 3 low voltage, bit 4 brown-out, bit 5 the system request and bit 7 the processor one-shot. Bit 6 always reads 0. Writing 1 to a bit clears it, writing 0 leaves it unchanged, and these writes do not need the unlock input.
- R4: A source sets its flag on the clock edge after it is asserted. Flags already set survive every chip-level reset that the block raises.
- R5: When several sources assert in the same cycle, all of their flags are set. A source that asserts in the same cycle as a write-1 clear of its flag leaves the flag set.
- R6: Writing 1 to control bit 0 (register address 1) sets a chip one-shot. The one-shot stays active for exactly two cycles and then clears itself, giving exactly two cycles of system reset. It also sets flag bit 0.
- R7: Writing 1 to control bit 1 sets a processor one-shot. It stays active for exactly two cycles and raises only `cpu_rst_o` for those two cycles. It also sets flag bit 7.
- R8: Control bit 2 holds `dma_rst_o` high, starting one edge after it is set, until software writes it to 0 or a chip-level reset clears it.
- R9: While `wr_unlock_i` is low, writes to the control register (address 1) and to the code field (address 2) are ignored.
- R10: While the code field holds 0x5AA5, `por_req_i` is ignored: it raises no output and sets no flag. Any other code value lets the request through.
- R11: Every chip-level reset clears the code field to 0, which enables the supply-monitor request again.
- R12: A read returns its data on `reg_rdata_o` after the clock edge that samples `reg_rd_i`. The control register reads back as {DMA hold, processor one-shot, chip one-shot} in bits 2 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Block power-up reset, synchronous, active high |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | ADDR_W | Register word address |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Registered read data |
| wr_unlock_i | input | 1 | From the protection block: protected writes allowed |
| por_req_i | input | 1 | Supply-monitor reset request |
| pin_req_i | input | 1 | Filtered reset-pin request |
| wdt_req_i | input | 1 | Watchdog reset request |
| lvr_req_i | input | 1 | Low-voltage reset request |
| bod_req_i | input | 1 | Brown-out reset request |
| sysreq_req_i | input | 1 | Processor system-reset request |
| sys_rst_o | output | 1 | Chip-wide reset |
| cpu_rst_o | output | 1 | Processor and flash-controller reset |
| dma_rst_o | output | 1 | DMA engine reset |

## Verification
A source request, or an active one-shot, appears on the reset outputs and in the flags at the next clock edge. A one-shot written at edge E0 becomes active at E0 and drives reset outputs for the two samples after E1 and E2. The output is low again after E3. Read data lands one edge after the read strobe, and a control-bit write reaches `dma_rst_o` one edge after the bit itself changes. The bench drives stimulus and samples outputs on the falling clock edge and counts these edges exactly. Its scoreboard pushes each expected read value when the read is issued and pops it at the first falling edge after the sampling edge.

// File: rtl/sysrst_pkg.sv
package sysrst_pkg;
  // cause flag positions
  localparam int unsigned FLAG_W   = 8;
  localparam int unsigned F_POR    = 0;
  localparam int unsigned F_PIN    = 1;
  localparam int unsigned F_WDT    = 2;
  localparam int unsigned F_LVR    = 3;
  localparam int unsigned F_BOD    = 4;
  localparam int unsigned F_SYSREQ = 5;
  localparam int unsigned F_CPU    = 7;
  // control register bit positions
  localparam int unsigned C_CHIP   = 0;
  localparam int unsigned C_CPU    = 1;
  localparam int unsigned C_DMA    = 2;
  localparam int unsigned OS_N     = 2;
  // register word addresses
  localparam int unsigned REG_FLAGS = 0;
  localparam int unsigned REG_CTRL  = 1;
  localparam int unsigned REG_PORC  = 2;
endpackage

// File: rtl/sysrst_oneshot.sv
module sysrst_oneshot #(
  parameter int unsigned PULSE_CYCLES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic fire_i,
  output logic active_o
);
  localparam int unsigned CW = (PULSE_CYCLES > 1) ? $clog2(PULSE_CYCLES) : 1;

  logic [CW-1:0] left_q;
  logic          act_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= 1'b0;
      left_q <= '0;
    end else if (fire_i) begin
      act_q  <= 1'b1;
      left_q <= CW'(PULSE_CYCLES - 1);
    end else if (act_q) begin
      if (left_q == '0) act_q <= 1'b0;
      else              left_q <= left_q - 1'b1;
    end
  end

  assign active_o = act_q;
endmodule

// File: rtl/sysrst_flags.sv
module sysrst_flags #(
  parameter int unsigned FLAG_W  = 8,
  parameter int unsigned POR_BIT = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [FLAG_W-1:0] set_i,
  input  logic [FLAG_W-1:0] clr_i,
  output logic [FLAG_W-1:0] flags_o
);
  localparam logic [FLAG_W-1:0] RST_VAL = FLAG_W'(1) << POR_BIT;

  logic [FLAG_W-1:0] flag_q;

  // only the block power-up reset touches this state; set beats clear
  always_ff @(posedge clk) begin
    if (rst) flag_q <= RST_VAL;
    else     flag_q <= (flag_q & ~clr_i) | set_i;
  end

  assign flags_o = flag_q;
endmodule

// File: rtl/sysrst_porcode.sv
module sysrst_porcode #(
  parameter int unsigned       CODE_W = 16,
  parameter logic [CODE_W-1:0] KEY    = 16'h5AA5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic [CODE_W-1:0] wdata_i,
  input  logic              chip_rst_i,
  output logic [CODE_W-1:0] code_o,
  output logic              por_en_o
);
  logic [CODE_W-1:0] code_q;

  always_ff @(posedge clk) begin
    if (rst || chip_rst_i) code_q <= '0;
    else if (wr_i)         code_q <= wdata_i;
  end

  assign code_o   = code_q;
  assign por_en_o = (code_q != KEY);
endmodule

// File: rtl/sysrst_ctrl.sv
module sysrst_ctrl
  import sysrst_pkg::*;
#(
  parameter int unsigned       ADDR_W       = 4,
  parameter int unsigned       DATA_W       = 16,
  parameter int unsigned       CODE_W       = 16,
  parameter int unsigned       PULSE_CYCLES = 2,
  parameter logic [CODE_W-1:0] POR_KEY      = 16'h5AA5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              wr_unlock_i,
  input  logic              por_req_i,
  input  logic              pin_req_i,
  input  logic              wdt_req_i,
  input  logic              lvr_req_i,
  input  logic              bod_req_i,
  input  logic              sysreq_req_i,
  output logic              sys_rst_o,
  output logic              cpu_rst_o,
  output logic              dma_rst_o
);
  localparam logic [ADDR_W-1:0] A_FLAGS = ADDR_W'(REG_FLAGS);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(REG_CTRL);
  localparam logic [ADDR_W-1:0] A_PORC  = ADDR_W'(REG_PORC);

  logic              wr_ctrl, wr_porc, wr_flags;
  logic [OS_N-1:0]   os_fire, os_act;
  logic              dma_q;
  logic              por_en, por_hit, chip_req;
  logic [CODE_W-1:0] por_code;
  logic [FLAG_W-1:0] flag_set, flag_clr, flag_q;
  logic              sys_q, cpu_q, dma_out_q;
  logic [DATA_W-1:0] rdata_q;

  assign wr_flags = reg_wr_i && (reg_addr_i == A_FLAGS);
  assign wr_ctrl  = reg_wr_i && wr_unlock_i && (reg_addr_i == A_CTRL);
  assign wr_porc  = reg_wr_i && wr_unlock_i && (reg_addr_i == A_PORC);

  // one-shot reset bits, one per control bit position 0..OS_N-1
  for (genvar g = 0; g < OS_N; g++) begin : g_os
    assign os_fire[g] = wr_ctrl && reg_wdata_i[g];
    sysrst_oneshot #(.PULSE_CYCLES(PULSE_CYCLES)) u_os (
      .clk      (clk),
      .rst      (rst),
      .fire_i   (os_fire[g]),
      .active_o (os_act[g])
    );
  end

  assign por_hit  = por_req_i && por_en;
  assign chip_req = por_hit | pin_req_i | wdt_req_i | lvr_req_i
                  | bod_req_i | sysreq_req_i | os_act[C_CHIP];

  sysrst_porcode #(.CODE_W(CODE_W), .KEY(POR_KEY)) u_porc (
    .clk        (clk),
    .rst        (rst),
    .wr_i       (wr_porc),
    .wdata_i    (reg_wdata_i[CODE_W-1:0]),
    .chip_rst_i (chip_req),
    .code_o     (por_code),
    .por_en_o   (por_en)
  );

  always_comb begin
    flag_set           = '0;
    flag_set[F_POR]    = por_hit | os_act[C_CHIP];
    flag_set[F_PIN]    = pin_req_i;
    flag_set[F_WDT]    = wdt_req_i;
    flag_set[F_LVR]    = lvr_req_i;
    flag_set[F_BOD]    = bod_req_i;
    flag_set[F_SYSREQ] = sysreq_req_i;
    flag_set[F_CPU]    = os_act[C_CPU];
    flag_clr           = wr_flags ? reg_wdata_i[FLAG_W-1:0] : '0;
  end

  sysrst_flags #(.FLAG_W(FLAG_W), .POR_BIT(F_POR)) u_flags (
    .clk     (clk),
    .rst     (rst),
    .set_i   (flag_set),
    .clr_i   (flag_clr),
    .flags_o (flag_q)
  );

  // level-held DMA reset bit; a chip reset returns it to 0
  always_ff @(posedge clk) begin
    if (rst || chip_req) dma_q <= 1'b0;
    else if (wr_ctrl)    dma_q <= reg_wdata_i[C_DMA];
  end

  // registered reset outputs, held high through block power-up
  always_ff @(posedge clk) begin
    if (rst) begin
      sys_q     <= 1'b1;
      cpu_q     <= 1'b1;
      dma_out_q <= 1'b1;
    end else begin
      sys_q     <= chip_req;
      cpu_q     <= chip_req | os_act[C_CPU];
      dma_out_q <= chip_req | dma_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else if (reg_rd_i) begin
      case (reg_addr_i)
        A_FLAGS: rdata_q <= DATA_W'(flag_q);
        A_CTRL:  rdata_q <= DATA_W'({dma_q, os_act[C_CPU], os_act[C_CHIP]});
        A_PORC:  rdata_q <= DATA_W'(por_code);
        default: rdata_q <= '0;
      endcase
    end
  end

  assign sys_rst_o   = sys_q;
  assign cpu_rst_o   = cpu_q;
  assign dma_rst_o   = dma_out_q;
  assign reg_rdata_o = rdata_q;
endmodule

// File: rtl/sysrst_ctrl_chk.sv
module sysrst_ctrl_chk
  import sysrst_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic              wr_unlock_i,
  input logic              por_req_i,
  input logic              pin_req_i,
  input logic              wdt_req_i,
  input logic              lvr_req_i,
  input logic              bod_req_i,
  input logic              sysreq_req_i,
  input logic              sys_rst_o,
  input logic              cpu_rst_o,
  input logic              dma_rst_o,
  input logic [FLAG_W-1:0] flags_i,
  input logic [OS_N-1:0]   os_i,
  input logic              dma_i,
  input logic              chip_req_i,
  input logic              por_en_i
);
  logic              rst_seen = 1'b0;
  logic              prev_ok  = 1'b0;
  logic [FLAG_W-1:0] keep_v;
  logic              any_src;

  always_ff @(posedge clk) begin
    if (rst) rst_seen <= 1'b1;
    prev_ok <= rst_seen && !rst;
  end

  assign keep_v  = flags_i & ~((reg_wr_i && reg_addr_i == ADDR_W'(REG_FLAGS))
                               ? reg_wdata_i[FLAG_W-1:0] : '0);
  assign any_src = pin_req_i | wdt_req_i | lvr_req_i | bod_req_i | sysreq_req_i;

  a_r1_reset_outputs: assert property (@(posedge clk)
    rst |=> (sys_rst_o && cpu_rst_o && dma_rst_o));

  a_r2_src_to_sys: assert property (@(posedge clk) disable iff (rst)
    any_src |=> (sys_rst_o && cpu_rst_o && dma_rst_o));

  a_r4_wdt_flag: assert property (@(posedge clk) disable iff (rst)
    wdt_req_i |=> flags_i[F_WDT]);

  a_r4_flags_sticky: assert property (@(posedge clk) disable iff (rst)
    prev_ok |-> ((flags_i & $past(keep_v)) == $past(keep_v)));

  a_r6_oneshot_hold: assert property (@(posedge clk) disable iff (rst)
    $rose(os_i[C_CHIP]) |=> os_i[C_CHIP]);

  a_r7_cpu_only: assert property (@(posedge clk) disable iff (rst)
    os_i[C_CPU] |=> cpu_rst_o);

  a_r9_ctrl_locked: assert property (@(posedge clk) disable iff (rst)
    (!wr_unlock_i && !chip_req_i) |=> $stable(dma_i));

  a_r10_por_blocked: assert property (@(posedge clk) disable iff (rst)
    (por_req_i && !por_en_i && !any_src && !os_i[C_CHIP]) |=> !sys_rst_o);
endmodule

bind sysrst_ctrl sysrst_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .reg_wr_i     (reg_wr_i),
  .reg_addr_i   (reg_addr_i),
  .reg_wdata_i  (reg_wdata_i),
  .wr_unlock_i  (wr_unlock_i),
  .por_req_i    (por_req_i),
  .pin_req_i    (pin_req_i),
  .wdt_req_i    (wdt_req_i),
  .lvr_req_i    (lvr_req_i),
  .bod_req_i    (bod_req_i),
  .sysreq_req_i (sysreq_req_i),
  .sys_rst_o    (sys_rst_o),
  .cpu_rst_o    (cpu_rst_o),
  .dma_rst_o    (dma_rst_o),
  .flags_i      (flag_q),
  .os_i         (os_act),
  .dma_i        (dma_q),
  .chip_req_i   (chip_req),
  .por_en_i     (por_en)
);

// File: tb/sysrst_ctrl_test.sv
module sysrst_ctrl_test;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned DATA_W = 16;
  localparam logic [ADDR_W-1:0] A_FLAGS = 4'd0;
  localparam logic [ADDR_W-1:0] A_CTRL  = 4'd1;
  localparam logic [ADDR_W-1:0] A_PORC  = 4'd2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 1'b0, reg_rd = 1'b0, unlock = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [DATA_W-1:0] reg_wdata = '0, reg_rdata;
  logic por_req = 1'b0, pin_req = 1'b0, wdt_req = 1'b0;
  logic lvr_req = 1'b0, bod_req = 1'b0, sysreq_req = 1'b0;
  logic sys_rst, cpu_rst, dma_rst;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [DATA_W-1:0] exp;
    string             tag;
  } rd_item_t;
  rd_item_t sbq[$];
  logic rd_seen = 1'b0;

  always #10 clk = ~clk;

  sysrst_ctrl uut (
    .clk(clk), .rst(rst), .reg_wr_i(reg_wr), .reg_rd_i(reg_rd),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .wr_unlock_i(unlock), .por_req_i(por_req), .pin_req_i(pin_req),
    .wdt_req_i(wdt_req), .lvr_req_i(lvr_req), .bod_req_i(bod_req),
    .sysreq_req_i(sysreq_req), .sys_rst_o(sys_rst), .cpu_rst_o(cpu_rst),
    .dma_rst_o(dma_rst)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_out(input string tag, input logic [2:0] exp);
    chk(tag, {29'd0, sys_rst, cpu_rst, dma_rst}, {29'd0, exp});
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  // driver: issue a read and queue its expected value
  task automatic rd(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] e, input string tag);
    rd_item_t it;
    it.exp = e; it.tag = tag;
    sbq.push_back(it);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  // monitor: compare read data one edge after the strobe
  always @(posedge clk) rd_seen <= reg_rd;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (sbq.size() == 0) begin
        checks++; errors++;
        $display("FAIL R12: actual unexpected read data %h expected none", reg_rdata);
      end else begin
        rd_item_t it;
        it = sbq.pop_front();
        chk(it.tag, {16'd0, reg_rdata}, {16'd0, it.exp});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    chk_out("R1 outputs during reset", 3'b111);
    rst = 1'b0;
    tick();
    chk_out("R1 outputs after reset", 3'b000);
    rd(A_FLAGS, 16'h0001, "R1 flags after power-up");
    rd(A_PORC, 16'h0000, "R12 code readback after reset");

    // R3 write-1 clear, no unlock needed
    wr(A_FLAGS, 16'h0001);
    rd(A_FLAGS, 16'h0000, "R3 flags cleared");

    // R2/R4 pin source
    pin_req = 1'b1; tick(); pin_req = 1'b0;
    chk_out("R2 pin drives all resets", 3'b111);
    tick();
    chk_out("R2 resets drop after pin", 3'b000);
    rd(A_FLAGS, 16'h0002, "R4 pin flag");

    // R4 earlier flag survives a watchdog chip reset
    wdt_req = 1'b1; tick(); wdt_req = 1'b0;
    chk_out("R2 watchdog drives resets", 3'b111);
    rd(A_FLAGS, 16'h0006, "R4 flags kept across chip reset");
    wr(A_FLAGS, 16'h0002);
    rd(A_FLAGS, 16'h0004, "R3 selective clear");
    wr(A_FLAGS, 16'h00FF);

    // R5 simultaneous sources
    lvr_req = 1'b1; bod_req = 1'b1; sysreq_req = 1'b1;
    tick();
    lvr_req = 1'b0; bod_req = 1'b0; sysreq_req = 1'b0;
    rd(A_FLAGS, 16'h0038, "R5 all simultaneous flags set");
    wr(A_FLAGS, 16'h00FF);
    rd(A_FLAGS, 16'h0000, "R3 bit 6 stays zero after clear");

    // R5 set beats clear in the same cycle
    wdt_req = 1'b1; reg_wr = 1'b1; reg_addr = A_FLAGS; reg_wdata = 16'h0004;
    tick();
    wdt_req = 1'b0; reg_wr = 1'b0;
    rd(A_FLAGS, 16'h0004, "R5 set wins over clear");
    wr(A_FLAGS, 16'h00FF);
    tick();

    // R9 locked control write
    unlock = 1'b0;
    wr(A_CTRL, 16'h0001);
    chk_out("R9 locked chip one-shot", 3'b000);
    tick();
    chk_out("R9 locked chip one-shot later", 3'b000);
    rd(A_FLAGS, 16'h0000, "R9 no flag from locked write");

    // R6 chip one-shot
    unlock = 1'b1;
    wr(A_CTRL, 16'h0001);
    chk_out("R6 one-shot edge", 3'b000);
    tick(); chk_out("R6 first reset cycle", 3'b111);
    tick(); chk_out("R6 second reset cycle", 3'b111);
    tick(); chk_out("R6 released after two", 3'b000);
    rd(A_FLAGS, 16'h0001, "R6 power-on flag set");
    rd(A_CTRL, 16'h0000, "R6 one-shot self-cleared");
    wr(A_FLAGS, 16'h00FF);

    // R7 processor one-shot
    wr(A_CTRL, 16'h0002);
    chk_out("R7 one-shot edge", 3'b000);
    tick(); chk_out("R7 first cycle cpu only", 3'b010);
    tick(); chk_out("R7 second cycle cpu only", 3'b010);
    tick(); chk_out("R7 released after two", 3'b000);
    rd(A_FLAGS, 16'h0080, "R7 cpu flag set");
    wr(A_FLAGS, 16'h00FF);

    // R8 DMA hold
    wr(A_CTRL, 16'h0004);
    chk_out("R8 dma not yet", 3'b000);
    tick(); chk_out("R8 dma held", 3'b001);
    repeat (4) tick();
    chk_out("R8 dma still held", 3'b001);
    rd(A_CTRL, 16'h0004, "R12 ctrl readback");
    unlock = 1'b0;
    wr(A_CTRL, 16'h0000);
    tick(); chk_out("R9 locked dma release ignored", 3'b001);
    unlock = 1'b1;
    wr(A_CTRL, 16'h0000);
    tick(); chk_out("R8 dma released", 3'b000);
    wr(A_CTRL, 16'h0004);
    tick(); chk_out("R8 dma held again", 3'b001);
    pin_req = 1'b1; tick(); pin_req = 1'b0;
    chk_out("R8 chip reset during hold", 3'b111);
    tick(); chk_out("R8 chip reset cleared hold", 3'b000);
    rd(A_CTRL, 16'h0000, "R8 hold bit cleared");
    wr(A_FLAGS, 16'h00FF);

    // R10 supply-monitor request and disable key
    por_req = 1'b1; tick(); por_req = 1'b0;
    chk_out("R10 enabled por request", 3'b111);
    rd(A_FLAGS, 16'h0001, "R10 por flag");
    wr(A_FLAGS, 16'h00FF);
    wr(A_PORC, 16'h5AA5);
    rd(A_PORC, 16'h5AA5, "R10 key stored");
    por_req = 1'b1; tick(); por_req = 1'b0;
    chk_out("R10 disabled por ignored", 3'b000);
    rd(A_FLAGS, 16'h0000, "R10 no flag when disabled");
    unlock = 1'b0;
    wr(A_PORC, 16'h1234);
    rd(A_PORC, 16'h5AA5, "R9 locked code write ignored");
    unlock = 1'b1;
    wr(A_PORC, 16'h5AA4);
    por_req = 1'b1; tick(); por_req = 1'b0;
    chk_out("R10 near-key value enables", 3'b111);
    rd(A_PORC, 16'h0000, "R11 code cleared by por reset");
    wr(A_FLAGS, 16'h00FF);

    // R11 other source re-enables
    wr(A_PORC, 16'h5AA5);
    bod_req = 1'b1; tick(); bod_req = 1'b0;
    rd(A_PORC, 16'h0000, "R11 code cleared by brown-out");
    por_req = 1'b1; tick(); por_req = 1'b0;
    chk_out("R11 por active again", 3'b111);
    rd(A_FLAGS, 16'h0011, "R11 flags bod and por");

    tick(); tick();
    chk("R12 scoreboard drained", sbq.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule